// File: doc/BRIEF.md
# FIFO Threshold Offset Register Port

This block stores the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Both offsets are `OFS_W` bits wide, where `OFS_W` is the base-2 logarithm of the FIFO depth in words. Each offset comes out of the block as a plain vector for the flag logic to use. The flag logic is not part of this block.

Software or a board controller can set the offsets in two ways. The first is a one-bit serial stream, shifted in while the load strobe and the shift enable are both active. The second is the FIFO's own write bus, used while the load strobe is active. The offsets can also be read back over the FIFO's read bus. The parallel write and parallel read paths share one select toggle. That toggle always visits the almost-empty offset first and the almost-full offset second. Read-backs must be spaced by at least one idle read-enable cycle. A read-back request that follows a low read enable is dropped.

The whole block runs on one clock. The serial shift is qualified by an enable on that clock.

Top module: `ofs_reg_port`

## Requirements
- R1: During reset and after it, both offsets equal 127 truncated to `OFS_W` bits and `rd_valid` is 0. After reset, the next parallel access targets the almost-empty offset and the next serial bit lands in almost-empty bit 0.
- R2: In a cycle with `ld_n`=0, `ser_en_n`=0 and no parallel write, one `ser_bit` is stored. Bits fill almost-empty bits 0 to `OFS_W`-1 in order (LSB first), then almost-full bits 0 to `OFS_W`-1. After 2·`OFS_W` bits the position returns to almost-empty bit 0.
- R3: In a cycle with `ld_n`=0 and `wr_en_n`=0, the low `OFS_W` bits of `wr_data` overwrite the selected offset. Upper bits are dropped. The offset changes on the same clock edge.
- R4: An accepted read (`ld_n`=0, `rd_en_n`=0) places the selected offset, zero-extended to `DATA_W`, on `rd_data` one clock later. `rd_valid` is 1 for that single cycle.
- R5: A read request in a cycle whose previous cycle had `rd_en_n`=0 is ignored. `rd_valid` stays 0 and the select does not advance.
- R6: Parallel writes and accepted reads share one select. Each accepted access moves it from almost-empty to almost-full, or from almost-full back to almost-empty.
- R7: When a parallel write and a read request occur in the same cycle, only the write happens. In a cycle with a parallel write, the serial bit is not stored and the serial position does not advance.
- R8: While `ld_n`=1, no offset changes and the serial position does not advance, whatever the other strobes do. No read is accepted.
- R9: `rd_data` holds its last value in cycles without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Offset access strobe, active low |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_bit | input | 1 | Serial offset data bit |
| wr_en_n | input | 1 | FIFO write enable, active low |
| wr_data | input | DATA_W | FIFO write bus |
| rd_en_n | input | 1 | FIFO read enable, active low |
| rd_data | output | DATA_W | Offset read-back value |
| rd_valid | output | 1 | Read-back value valid this cycle |
| ae_offset | output | OFS_W | Almost-empty threshold offset |
| af_offset | output | OFS_W | Almost-full threshold offset |

## Verification
The bench builds the block with `OFS_W`=8 and `DATA_W`=18. With these values the reset default of 127 fits without truncation. The 18-bit bus carries ten upper bits that a write must drop. A full serial pass takes 16 shifts, which keeps the position wrap back to almost-empty bit 0 short enough to test directly. The narrow offsets also make each serial bit position easy to check by value.

// File: rtl/ofs_pkg.sv
// Package ofs_pkg
// Shared types for the offset register port: names the two offset slots.
package ofs_pkg;
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/ofs_serial_loader.sv
// Module ofs_serial_loader
// Walks a bit position across almost-empty then almost-full, one bit per
// enabled cycle, LSB first, wrapping after 2*OFS_W bits.
// Assumes OFS_W >= 2. A parallel write in the same cycle blocks the shift.
module ofs_serial_loader #(
    parameter int OFS_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_n,
    input  logic                         ser_en_n,
    input  logic                         par_wr,
    output logic                         shift_en,
    output logic                         shift_af,
    output logic [$clog2(OFS_W)-1:0]     shift_pos
);
    localparam int CNT_W = $clog2(2 * OFS_W);
    localparam int POS_W = $clog2(OFS_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(2 * OFS_W - 1);
    localparam logic [CNT_W-1:0] HALF  = CNT_W'(OFS_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rel_pos;

    // Shift qualifier: strobe and enable active, no parallel write
    assign shift_en  = !ld_n && !ser_en_n && !par_wr;
    assign shift_af  = (cnt_q >= HALF);
    assign rel_pos   = shift_af ? (cnt_q - HALF) : cnt_q;
    assign shift_pos = POS_W'(rel_pos);

    // Position counter: advances per stored bit, wraps at the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ofs_access_seq.sv
// Module ofs_access_seq
// Decides which parallel accesses are taken and keeps the shared
// almost-empty/almost-full select. A write beats a read in the same cycle.
// A read is only taken if read enable was high in the previous cycle.
module ofs_access_seq
    import ofs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ld_n,
    input  logic      wr_en_n,
    input  logic      rd_en_n,
    output logic      par_wr,
    output logic      par_rd,
    output ofs_sel_e  sel
);
    logic rd_idle_q;

    // Access decode: write first, read gated by the spacing rule
    assign par_wr = !ld_n && !wr_en_n;
    assign par_rd = !ld_n && !rd_en_n && rd_idle_q && !par_wr;

    // Spacing history: remembers whether read enable was high last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idle_q <= 1'b1;
        end else begin
            rd_idle_q <= rd_en_n;
        end
    end

    // Select toggle: flips on every taken access, starts at almost-empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= SEL_AE;
        end else if (par_wr || par_rd) begin
            sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end
endmodule

// File: rtl/ofs_regfile.sv
// Module ofs_regfile
// Holds both offsets plus the read-back register. A parallel write replaces
// the selected offset with the truncated bus value. A serial shift updates one
// bit of one offset. Assumes DATA_W >= OFS_W.
module ofs_regfile
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int DATA_W  = 18,
    parameter int DEF_OFS = 127
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      par_wr,
    input  logic                      par_rd,
    input  ofs_sel_e                  sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      shift_en,
    input  logic                      shift_af,
    input  logic [$clog2(OFS_W)-1:0]  shift_pos,
    input  logic                      ser_bit,
    output logic [OFS_W-1:0]          ae_offset,
    output logic [OFS_W-1:0]          af_offset,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_valid
);
    localparam logic [OFS_W-1:0] DEF_T = OFS_W'(DEF_OFS);

    logic [1:0][OFS_W-1:0] ofs_all;
    logic [OFS_W-1:0]      wr_trunc;

    assign wr_trunc = OFS_W'(wr_data);

    for (genvar g = 0; g < 2; g++) begin : g_slot
        localparam logic ME = 1'(g);
        logic [OFS_W-1:0] q;

        // Slot register: parallel overwrite, else single-bit serial update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= DEF_T;
            end else if (par_wr && (sel == ofs_sel_e'(ME))) begin
                q <= wr_trunc;
            end else if (shift_en && (shift_af == ME)) begin
                q[shift_pos] <= ser_bit;
            end
        end

        assign ofs_all[g] = q;
    end

    assign ae_offset = ofs_all[0];
    assign af_offset = ofs_all[1];

    // Read-back port: captures the selected slot on a taken read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= par_rd;
            if (par_rd) begin
                rd_data <= DATA_W'(ofs_all[sel]);
            end
        end
    end
endmodule

// File: rtl/ofs_reg_port.sv
// Module ofs_reg_port
// Top of the threshold offset register port. It joins the serial loader, the
// access sequencer and the register file. One clock with a synchronous,
// active-low reset. Assumes OFS_W >= 2 and DATA_W >= OFS_W.
module ofs_reg_port
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int DATA_W  = 18,
    parameter int DEF_OFS = 127
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_n,
    input  logic               ser_en_n,
    input  logic               ser_bit,
    input  logic               wr_en_n,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en_n,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic [OFS_W-1:0]   ae_offset,
    output logic [OFS_W-1:0]   af_offset
);
    localparam int POS_W = $clog2(OFS_W);

    logic              par_wr;
    logic              par_rd;
    ofs_sel_e          sel;
    logic              shift_en;
    logic              shift_af;
    logic [POS_W-1:0]  shift_pos;

    ofs_access_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_n    (ld_n),
        .wr_en_n (wr_en_n),
        .rd_en_n (rd_en_n),
        .par_wr  (par_wr),
        .par_rd  (par_rd),
        .sel     (sel)
    );

    ofs_serial_loader #(.OFS_W(OFS_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .ser_en_n  (ser_en_n),
        .par_wr    (par_wr),
        .shift_en  (shift_en),
        .shift_af  (shift_af),
        .shift_pos (shift_pos)
    );

    ofs_regfile #(
        .OFS_W   (OFS_W),
        .DATA_W  (DATA_W),
        .DEF_OFS (DEF_OFS)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_wr    (par_wr),
        .par_rd    (par_rd),
        .sel       (sel),
        .wr_data   (wr_data),
        .shift_en  (shift_en),
        .shift_af  (shift_af),
        .shift_pos (shift_pos),
        .ser_bit   (ser_bit),
        .ae_offset (ae_offset),
        .af_offset (af_offset),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/ofs_reg_port_chk.sv
// Module ofs_reg_port_chk
// Property checker for ofs_reg_port, attached through bind below.
module ofs_reg_port_chk
    import ofs_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int DATA_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_n,
    input logic [DATA_W-1:0]  wr_data,
    input logic               par_wr,
    input logic               par_rd,
    input ofs_sel_e           sel,
    input logic [OFS_W-1:0]   ae_offset,
    input logic [OFS_W-1:0]   af_offset,
    input logic [DATA_W-1:0]  rd_data,
    input logic               rd_valid
);
    // R5: taken reads can never produce read-back in two cycles running
    p_rd_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: every taken access flips the shared select
    p_sel_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr || par_rd) |=> (sel != $past(sel)));

    // R5: without a taken access the select holds
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_wr || par_rd) |=> $stable(sel));

    // R3: a write aimed at almost-empty stores the truncated bus value
    p_load_ae_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && sel == SEL_AE) |=> (ae_offset == OFS_W'($past(wr_data))));

    // R3: a write aimed at almost-full stores the truncated bus value
    p_load_af_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && sel == SEL_AF) |=> (af_offset == OFS_W'($past(wr_data))));

    // R8: with the strobe inactive neither offset moves
    p_ld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> ($stable(ae_offset) && $stable(af_offset)));

    // R4: read-back of almost-full returns the value held at request time
    p_read_af_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rd && sel == SEL_AF) |=> (rd_valid && rd_data == DATA_W'($past(af_offset))));

    // R9: read-back bus holds when nothing is read
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !par_rd |=> $stable(rd_data));
endmodule

bind ofs_reg_port ofs_reg_port_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .wr_data   (wr_data),
    .par_wr    (par_wr),
    .par_rd    (par_rd),
    .sel       (sel),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/ofs_reg_port_tb_top.sv
// Bench for ofs_reg_port: vector table for the parallel paths, then
// directed serial, priority, strobe-inactive and mid-run reset tests.
module ofs_reg_port_tb_top;
    localparam int OFS_W  = 8;
    localparam int DATA_W = 18;
    localparam int NVEC   = 19;

    // Ops: 0 idle, 1 write, 2 read, 3 write+read, 4 write with ld_n high,
    //      5 read with ld_n high
    // Row: {op[2:0], data[17:0], exp_ae[7:0], exp_af[7:0], exp_valid, exp_rd[7:0]}
    localparam logic [45:0] VEC [NVEC] = '{
        {3'd1, 18'h030A5, 8'hA5, 8'h7F, 1'b0, 8'h00},
        {3'd1, 18'h00012, 8'hA5, 8'h12, 1'b0, 8'h00},
        {3'd2, 18'h00000, 8'hA5, 8'h12, 1'b1, 8'hA5},
        {3'd0, 18'h00000, 8'hA5, 8'h12, 1'b0, 8'hA5},
        {3'd2, 18'h00000, 8'hA5, 8'h12, 1'b1, 8'h12},
        {3'd2, 18'h00000, 8'hA5, 8'h12, 1'b0, 8'h12},
        {3'd0, 18'h00000, 8'hA5, 8'h12, 1'b0, 8'h12},
        {3'd2, 18'h00000, 8'hA5, 8'h12, 1'b1, 8'hA5},
        {3'd1, 18'h3FF40, 8'hA5, 8'h40, 1'b0, 8'hA5},
        {3'd0, 18'h00000, 8'hA5, 8'h40, 1'b0, 8'hA5},
        {3'd2, 18'h00000, 8'hA5, 8'h40, 1'b1, 8'hA5},
        {3'd0, 18'h00000, 8'hA5, 8'h40, 1'b0, 8'hA5},
        {3'd2, 18'h00000, 8'hA5, 8'h40, 1'b1, 8'h40},
        {3'd0, 18'h00000, 8'hA5, 8'h40, 1'b0, 8'h40},
        {3'd3, 18'h00055, 8'h55, 8'h40, 1'b0, 8'h40},
        {3'd0, 18'h00000, 8'h55, 8'h40, 1'b0, 8'h40},
        {3'd2, 18'h00000, 8'h55, 8'h40, 1'b1, 8'h40},
        {3'd4, 18'h000FF, 8'h55, 8'h40, 1'b0, 8'h40},
        {3'd5, 18'h00000, 8'h55, 8'h40, 1'b0, 8'h40}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_n = 1'b1;
    logic              ser_en_n = 1'b1;
    logic              ser_bit = 1'b0;
    logic              wr_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en_n = 1'b1;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic [OFS_W-1:0]  ae_offset;
    logic [OFS_W-1:0]  af_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ofs_reg_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .ser_en_n  (ser_en_n),
        .ser_bit   (ser_bit),
        .wr_en_n   (wr_en_n),
        .wr_data   (wr_data),
        .rd_en_n   (rd_en_n),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .ae_offset (ae_offset),
        .af_offset (af_offset)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        ld_n = 1'b1; ser_en_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        wr_data = '0; ser_bit = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            ld_n = 1'b0; ser_en_n = 1'b0; ser_bit = bits[i];
            @(negedge clk);
        end
        go_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ae reset", 32'(ae_offset), 32'h7F);
        chk("R1", "af reset", 32'(af_offset), 32'h7F);
        chk("R1", "valid reset", 32'(rd_valid), 32'h0);
        chk("R1", "rd_data reset", 32'(rd_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] op;
            op = VEC[v][45:43];
            go_idle();
            wr_data = VEC[v][42:25];
            case (op)
                3'd1: begin ld_n = 1'b0; wr_en_n = 1'b0; end
                3'd2: begin ld_n = 1'b0; rd_en_n = 1'b0; end
                3'd3: begin ld_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0; end
                3'd4: begin wr_en_n = 1'b0; end
                3'd5: begin rd_en_n = 1'b0; end
                default: ;
            endcase
            @(negedge clk);
            chk("R3/R6/R7/R8", $sformatf("row %0d ae", v), 32'(ae_offset), 32'(VEC[v][24:17]));
            chk("R3/R6/R7/R8", $sformatf("row %0d af", v), 32'(af_offset), 32'(VEC[v][16:9]));
            chk("R4/R5", $sformatf("row %0d valid", v), 32'(rd_valid), 32'(VEC[v][8]));
            chk("R4/R9", $sformatf("row %0d rd_data", v), 32'(rd_data), 32'(VEC[v][7:0]));
        end
        go_idle();
        @(negedge clk);

        // R2: a full serial pass, almost-empty first, LSB first
        shift_bits(32'h0000C33C, 16);
        chk("R2", "serial ae", 32'(ae_offset), 32'h3C);
        chk("R2", "serial af", 32'(af_offset), 32'hC3);
        // R2: wrap back to almost-empty bit 0
        shift_bits(32'h00000005, 3);
        chk("R2", "wrap ae", 32'(ae_offset), 32'h3D);
        chk("R2", "wrap af", 32'(af_offset), 32'hC3);

        // R7: parallel write beats serial shift in the same cycle
        ld_n = 1'b0; wr_en_n = 1'b0; ser_en_n = 1'b0; ser_bit = 1'b0;
        wr_data = 18'h00077;
        @(negedge clk);
        go_idle();
        chk("R7", "write over shift ae", 32'(ae_offset), 32'h77);
        chk("R7", "write over shift af", 32'(af_offset), 32'hC3);
        shift_bits(32'h1, 1);
        chk("R7", "serial position held", 32'(ae_offset), 32'h7F);

        // R8: strobe inactive blocks shift and write
        ser_en_n = 1'b0; ser_bit = 1'b0; wr_en_n = 1'b0; wr_data = '0;
        @(negedge clk);
        go_idle();
        chk("R8", "no change ae", 32'(ae_offset), 32'h7F);
        chk("R8", "no change af", 32'(af_offset), 32'hC3);
        shift_bits(32'h0, 1);
        chk("R8", "position not advanced", 32'(ae_offset), 32'h6F);

        // R1: mid-run reset restores defaults, select and serial position
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset ae", 32'(ae_offset), 32'h7F);
        chk("R1", "mid reset af", 32'(af_offset), 32'h7F);
        chk("R1", "mid reset valid", 32'(rd_valid), 32'h0);
        rst_n = 1'b1;
        ld_n = 1'b0; wr_en_n = 1'b0; wr_data = 18'h00011;
        @(negedge clk);
        go_idle();
        chk("R1", "select at ae", 32'(ae_offset), 32'h11);
        chk("R1", "af untouched", 32'(af_offset), 32'h7F);
        shift_bits(32'h0, 1);
        chk("R1", "serial at ae bit0", 32'(ae_offset), 32'h10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule